// File: doc/BRIEF.md
# Fixed-Latency Tile Rasterizer Array

This block draws a batch of already set-up triangles into an 8-by-8 pixel tile. The tile lives in two local stores: a colour store and a depth store. There are eight column engines, one for each pixel column of the tile. Each engine keeps its own slice of both stores, walks its column one row at a time, tests whether the pixel is covered by the triangle, works out an interpolated depth and keeps the nearest fragment.

A sequencer sets the timing. It clears the tile at the start of each run, hands each triangle to every engine at the same moment, and steps all engines through the rows in lockstep. Each row takes the same three cycles whether or not any pixel is covered. The run time therefore depends only on the triangle count and never on the geometry.

The host works as follows. It pulses `start` with a triangle count. It serves the triangle data for the index shown on `tri_idx`. It waits for `done`. It then reads the finished tile through the pixel readout port.

Top module: `trz_tile_raster`

## Requirements
- R1: For a count n from 1 to 16, `busy` is high for exactly 33 + 30*(n-1) consecutive cycles, starting in the cycle after `start` is sampled. `done` is high for exactly one cycle, in the first cycle after `busy` drops.
- R2: A count of 0 clears the tile and runs no triangle. `busy` is high for 9 cycles and is followed by the one-cycle `done`.
- R3: A count above 16 is treated as 16 and takes 483 busy cycles.
- R4: `start` is ignored while `busy` or `done` is high. Such a pulse changes neither the timing nor the tile contents.
- R5: Every accepted start sets every depth entry to all-ones and every colour entry to zero, which discards the previous tile.
- R6: The edge value k at column c and row r is `edgek + c*dxk + r*dyk`. All inputs are signed 16-bit. Column 0 is the left column and row 0 is the top row. A pixel is covered when all three edge values are greater than or equal to zero.
- R7: The depth of a covered pixel is floor((V0*z0 + V1*z1 + V2*z2) * area_recp / 65536). Vk is edge value k at that pixel, z and area_recp are unsigned, and the result saturates at 65535.
- R8: A covered pixel is written only when its depth is strictly less than the stored depth. An equal depth leaves both stores unchanged.
- R9: Triangles are processed in order 0 to n-1. `tri_idx` shows the triangle being set up, and its data inputs must stay valid while it is shown.
- R10: `rd_row` and `rd_col` select one pixel. `rd_color` and `rd_depth` return its stored values in the same cycle.
- R11: After reset, `busy`, `done` and `tri_idx` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a tile run |
| tri_num | input | 5 | Triangle count for this run |
| tri_idx | output | 4 | Index of the triangle whose data is requested |
| edge0 | input | 16 | Edge value 0 at the top-left pixel |
| edge1 | input | 16 | Edge value 1 at the top-left pixel |
| edge2 | input | 16 | Edge value 2 at the top-left pixel |
| dx0 | input | 16 | Step of edge 0 per column |
| dx1 | input | 16 | Step of edge 1 per column |
| dx2 | input | 16 | Step of edge 2 per column |
| dy0 | input | 16 | Step of edge 0 per row |
| dy1 | input | 16 | Step of edge 1 per row |
| dy2 | input | 16 | Step of edge 2 per row |
| area_recp | input | 16 | Reciprocal of the triangle area, 16 fraction bits |
| z0 | input | 16 | Depth weighted by edge value 0 |
| z1 | input | 16 | Depth weighted by edge value 1 |
| z2 | input | 16 | Depth weighted by edge value 2 |
| color | input | 24 | Colour written for covered pixels |
| rd_row | input | 3 | Readout row |
| rd_col | input | 3 | Readout column |
| rd_color | output | 24 | Colour of the selected pixel |
| rd_depth | output | 16 | Depth of the selected pixel |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |

## Verification
A sequencer that loses its place shows up on `busy` and `done` in the very cycle it goes wrong. The bench compares these two outputs against a cycle-counting model on every clock, so a phase or counter error is caught at once, not just at the end of the run. A wrong edge step, a depth error or a broken compare inside one column engine leaves no trace until readout. It then appears as wrong colour or depth values in that column, so every pixel of every tile is compared against a behavioural rasterizer. Directed tiles cover the two depth corner cases, equal depth and saturated depth, so that a wrong compare or a missing clamp changes a pixel that can be checked.

// File: rtl/trz_pkg.sv
package trz_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_CLEAR,
      ST_SETUP,
      ST_ROWS,
      ST_DONE
   } trz_state_e;

   // cycles each engine spends on one row: cover test, depth scale, store
   localparam int unsigned ROW_PHASES = 3;
endpackage

// File: rtl/trz_ctrl.sv
module trz_ctrl
   import trz_pkg::*;
#(
   parameter int unsigned ROWS      = 8,
   parameter int unsigned MAX_TRI   = 16,
   parameter int unsigned SETUP_CYC = 6,
   parameter int unsigned CLR_CYC   = 9
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [$clog2(MAX_TRI+1)-1:0] tri_num,
   output logic [$clog2(MAX_TRI)-1:0]   tri_idx,
   output logic                         load,
   output logic                         clr_en,
   output logic [$clog2(ROWS)-1:0]      clr_row,
   output logic                         row_act,
   output logic [$clog2(ROWS)-1:0]      row_idx,
   output logic [1:0]                   phase,
   output logic                         busy,
   output logic                         done
);
   localparam int unsigned NW   = $clog2(MAX_TRI+1);
   localparam int unsigned IW   = $clog2(MAX_TRI);
   localparam int unsigned RB   = $clog2(ROWS);
   localparam int unsigned CNTW = $clog2(CLR_CYC) + 1;

   trz_state_e        state_q;
   logic [NW-1:0]     ntri_q;
   logic [IW-1:0]     idx_q;
   logic [CNTW-1:0]   cnt_q;
   logic [RB-1:0]     row_q;
   logic [1:0]        ph_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ntri_q  <= '0;
         idx_q   <= '0;
         cnt_q   <= '0;
         row_q   <= '0;
         ph_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  ntri_q  <= (tri_num > NW'(MAX_TRI)) ? NW'(MAX_TRI) : tri_num;
                  idx_q   <= '0;
                  cnt_q   <= '0;
                  state_q <= ST_CLEAR;
               end
            end
            ST_CLEAR: begin
               if (cnt_q == CNTW'(CLR_CYC-1)) begin
                  cnt_q   <= '0;
                  row_q   <= '0;
                  ph_q    <= '0;
                  state_q <= (ntri_q == '0) ? ST_DONE : ST_ROWS;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_SETUP: begin
               if (cnt_q == CNTW'(SETUP_CYC-1)) begin
                  cnt_q   <= '0;
                  row_q   <= '0;
                  ph_q    <= '0;
                  state_q <= ST_ROWS;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ROWS: begin
               if (ph_q == 2'(ROW_PHASES-1)) begin
                  ph_q <= '0;
                  if (row_q == RB'(ROWS-1)) begin
                     if (NW'(idx_q) + 1'b1 == ntri_q) begin
                        state_q <= ST_DONE;
                     end else begin
                        idx_q   <= idx_q + 1'b1;
                        cnt_q   <= '0;
                        state_q <= ST_SETUP;
                     end
                  end else begin
                     row_q <= row_q + 1'b1;
                  end
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            ST_DONE:  state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   // the first setup hides under the clear; later setups stand alone
   assign load    = ((state_q == ST_CLEAR) && (cnt_q == CNTW'(SETUP_CYC-1)) && (ntri_q != '0))
                 || ((state_q == ST_SETUP) && (cnt_q == CNTW'(SETUP_CYC-1)));
   assign clr_en  = (state_q == ST_CLEAR) && (cnt_q < CNTW'(ROWS));
   assign clr_row = cnt_q[RB-1:0];
   assign row_act = (state_q == ST_ROWS);
   assign row_idx = row_q;
   assign phase   = ph_q;
   assign tri_idx = idx_q;
   assign busy    = (state_q == ST_CLEAR) || (state_q == ST_SETUP) || (state_q == ST_ROWS);
   assign done    = (state_q == ST_DONE);

   a_r1_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   a_r1_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && !busy);
   a_r4_count_held: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |=> $stable(ntri_q));
   a_r3_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> (ntri_q <= NW'(MAX_TRI)));
   a_r9_index_step: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == ST_SETUP) && ($past(state_q) == ST_ROWS)) |-> (tri_idx == IW'($past(tri_idx) + 1'b1)));
endmodule

// File: rtl/trz_column.sv
module trz_column
   import trz_pkg::*;
#(
   parameter int unsigned COL  = 0,
   parameter int unsigned ROWS = 8,
   parameter int unsigned EW   = 16,
   parameter int unsigned ZW   = 16,
   parameter int unsigned RW   = 16,
   parameter int unsigned CW   = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    load,
   input  logic                    clr_en,
   input  logic [$clog2(ROWS)-1:0] clr_row,
   input  logic                    row_act,
   input  logic [$clog2(ROWS)-1:0] row_idx,
   input  logic [1:0]              phase,
   input  logic [2:0][EW-1:0]      e_in,
   input  logic [2:0][EW-1:0]      a_in,
   input  logic [2:0][EW-1:0]      b_in,
   input  logic [2:0][ZW-1:0]      z_in,
   input  logic [RW-1:0]           recp_in,
   input  logic [CW-1:0]           color_in,
   input  logic [$clog2(ROWS)-1:0] rd_row,
   output logic [CW-1:0]           rd_color,
   output logic [ZW-1:0]           rd_depth
);
   localparam int unsigned EXW = EW + 4;        // room for 7 column and 7 row steps
   localparam int unsigned SW  = EXW + ZW + 3;  // three weighted depth terms
   localparam int unsigned PW  = SW + RW + 1;   // sum times reciprocal
   localparam logic signed [EXW-1:0] COLV = EXW'(COL);
   localparam logic [1:0] PH_COVER = 2'd0;
   localparam logic [1:0] PH_SCALE = 2'd1;
   localparam logic [1:0] PH_STORE = 2'(ROW_PHASES-1);

   function automatic logic signed [EXW-1:0] sx(input logic [EW-1:0] v);
      return {{(EXW-EW){v[EW-1]}}, v};
   endfunction

   logic signed [EXW-1:0] e_q [3];
   logic signed [EXW-1:0] e_start [3];
   logic [EW-1:0]         b_q [3];
   logic [ZW-1:0]         z_q [3];
   logic [RW-1:0]         recp_q;
   logic [CW-1:0]         col_q;
   logic                  cov_q;
   logic signed [SW-1:0]  sum_q;
   logic signed [SW-1:0]  sum_d;
   logic signed [SW-1:0]  ew [3];
   logic signed [SW-1:0]  zw [3];
   logic signed [PW-1:0]  prod_d;
   logic signed [PW-1:0]  sh_d;
   logic [ZW-1:0]         dep_q;
   logic [ZW-1:0]         dep_d;
   logic                  cov_d;
   logic [ZW-1:0]         zbuf [ROWS];
   logic [CW-1:0]         cbuf [ROWS];

   always_comb begin
      sum_d = '0;
      for (int i = 0; i < 3; i++) begin
         e_start[i] = sx(e_in[i]) + sx(a_in[i]) * COLV;
         ew[i]      = {{(SW-EXW){e_q[i][EXW-1]}}, e_q[i]};
         zw[i]      = {{(SW-ZW){1'b0}}, z_q[i]};
         sum_d      = sum_d + ew[i] * zw[i];
      end
      cov_d  = ~e_q[0][EXW-1] & ~e_q[1][EXW-1] & ~e_q[2][EXW-1];
      prod_d = {{(PW-SW){sum_q[SW-1]}}, sum_q} * {{(PW-RW){1'b0}}, recp_q};
      sh_d   = prod_d >>> RW;
      if (sh_d[PW-1] || (|sh_d[PW-1:ZW])) dep_d = '1;
      else                                dep_d = sh_d[ZW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < 3; i++) begin
            e_q[i] <= '0;
            b_q[i] <= '0;
            z_q[i] <= '0;
         end
         recp_q <= '0;
         col_q  <= '0;
         cov_q  <= 1'b0;
         sum_q  <= '0;
         dep_q  <= '0;
      end else if (load) begin
         for (int i = 0; i < 3; i++) begin
            e_q[i] <= e_start[i];
            b_q[i] <= b_in[i];
            z_q[i] <= z_in[i];
         end
         recp_q <= recp_in;
         col_q  <= color_in;
      end else if (row_act) begin
         case (phase)
            PH_COVER: begin
               cov_q <= cov_d;
               sum_q <= sum_d;
            end
            PH_SCALE: dep_q <= dep_d;
            PH_STORE: begin
               for (int i = 0; i < 3; i++) e_q[i] <= e_q[i] + sx(b_q[i]);
            end
            default: ;
         endcase
      end
   end

   // the store phase runs every row; only the write enable depends on data
   always_ff @(posedge clk) begin
      if (clr_en) begin
         zbuf[clr_row] <= '1;
         cbuf[clr_row] <= '0;
      end else if (row_act && (phase == PH_STORE) && cov_q && (dep_q < zbuf[row_idx])) begin
         zbuf[row_idx] <= dep_q;
         cbuf[row_idx] <= col_q;
      end
   end

   assign rd_depth = zbuf[rd_row];
   assign rd_color = cbuf[rd_row];

   for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
      a_r5_clear_row: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_en && (clr_row == r)) |=> ((zbuf[r] == '1) && (cbuf[r] == '0)));
      a_r8_depth_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
         !(clr_en && (clr_row == r)) |=> (zbuf[r] <= $past(zbuf[r])));
   end
endmodule

// File: rtl/trz_tile_raster.sv
module trz_tile_raster #(
   parameter int unsigned COLS      = 8,
   parameter int unsigned ROWS      = 8,
   parameter int unsigned MAX_TRI   = 16,
   parameter int unsigned SETUP_CYC = 6,
   parameter int unsigned CLR_CYC   = 9,
   parameter int unsigned EW        = 16,
   parameter int unsigned ZW        = 16,
   parameter int unsigned RW        = 16,
   parameter int unsigned CW        = 24,
   parameter bit          RD_REG    = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start,
   input  logic [$clog2(MAX_TRI+1)-1:0] tri_num,
   output logic [$clog2(MAX_TRI)-1:0]   tri_idx,
   input  logic [EW-1:0]                edge0,
   input  logic [EW-1:0]                edge1,
   input  logic [EW-1:0]                edge2,
   input  logic [EW-1:0]                dx0,
   input  logic [EW-1:0]                dx1,
   input  logic [EW-1:0]                dx2,
   input  logic [EW-1:0]                dy0,
   input  logic [EW-1:0]                dy1,
   input  logic [EW-1:0]                dy2,
   input  logic [RW-1:0]                area_recp,
   input  logic [ZW-1:0]                z0,
   input  logic [ZW-1:0]                z1,
   input  logic [ZW-1:0]                z2,
   input  logic [CW-1:0]                color,
   input  logic [$clog2(ROWS)-1:0]      rd_row,
   input  logic [$clog2(COLS)-1:0]      rd_col,
   output logic [CW-1:0]                rd_color,
   output logic [ZW-1:0]                rd_depth,
   output logic                         busy,
   output logic                         done
);
   localparam int unsigned RB = $clog2(ROWS);

   if (CLR_CYC < ROWS) begin : g_bad_clear
      $error("clear phase shorter than the row count");
   end
   if (CLR_CYC < SETUP_CYC || SETUP_CYC < 1) begin : g_bad_setup
      $error("first setup must fit inside the clear phase");
   end
   if (ROWS < 2 || (1 << RB) != ROWS || COLS < 2 || (1 << $clog2(COLS)) != COLS) begin : g_bad_shape
      $error("tile sides must be powers of two, at least two");
   end
   if (MAX_TRI < 2 || EW < 2) begin : g_bad_size
      $error("triangle batch and edge width too small");
   end

   logic            load, clr_en, row_act;
   logic [RB-1:0]   clr_row, row_idx;
   logic [1:0]      phase;
   logic [2:0][EW-1:0] e_pk, a_pk, b_pk;
   logic [2:0][ZW-1:0] z_pk;
   logic [CW-1:0]   col_c [COLS];
   logic [ZW-1:0]   col_z [COLS];

   assign e_pk = {edge2, edge1, edge0};
   assign a_pk = {dx2, dx1, dx0};
   assign b_pk = {dy2, dy1, dy0};
   assign z_pk = {z2, z1, z0};

   trz_ctrl #(
      .ROWS(ROWS), .MAX_TRI(MAX_TRI), .SETUP_CYC(SETUP_CYC), .CLR_CYC(CLR_CYC)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .tri_num(tri_num), .tri_idx(tri_idx),
      .load(load), .clr_en(clr_en), .clr_row(clr_row), .row_act(row_act),
      .row_idx(row_idx), .phase(phase), .busy(busy), .done(done)
   );

   for (genvar c = 0; c < COLS; c++) begin : g_col
      trz_column #(
         .COL(c), .ROWS(ROWS), .EW(EW), .ZW(ZW), .RW(RW), .CW(CW)
      ) u_col (
         .clk(clk), .rst_n(rst_n), .load(load), .clr_en(clr_en), .clr_row(clr_row),
         .row_act(row_act), .row_idx(row_idx), .phase(phase),
         .e_in(e_pk), .a_in(a_pk), .b_in(b_pk), .z_in(z_pk),
         .recp_in(area_recp), .color_in(color), .rd_row(rd_row),
         .rd_color(col_c[c]), .rd_depth(col_z[c])
      );
   end

   if (RD_REG) begin : g_rd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_color <= '0;
            rd_depth <= '0;
         end else begin
            rd_color <= col_c[rd_col];
            rd_depth <= col_z[rd_col];
         end
      end
   end else begin : g_rd_comb
      assign rd_color = col_c[rd_col];
      assign rd_depth = col_z[rd_col];
   end
endmodule

// File: tb/trz_tile_raster_tb.sv
module trz_tile_raster_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [4:0]  tri_num = '0;
   logic [3:0]  tri_idx;
   logic [2:0]  rd_row = '0, rd_col = '0;
   logic [23:0] rd_color;
   logic [15:0] rd_depth;
   logic        busy, done;

   logic [15:0] t_e [16][3];
   logic [15:0] t_a [16][3];
   logic [15:0] t_b [16][3];
   logic [15:0] t_z [16][3];
   logic [15:0] t_r [16];
   logic [23:0] t_c [16];

   int checks = 0, fails = 0;
   bit wd = 1'b0;
   int rem = 0;
   bit mdone = 1'b0;

   always #5 clk = ~clk;

   trz_tile_raster u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .tri_num(tri_num), .tri_idx(tri_idx),
      .edge0(t_e[tri_idx][0]), .edge1(t_e[tri_idx][1]), .edge2(t_e[tri_idx][2]),
      .dx0(t_a[tri_idx][0]), .dx1(t_a[tri_idx][1]), .dx2(t_a[tri_idx][2]),
      .dy0(t_b[tri_idx][0]), .dy1(t_b[tri_idx][1]), .dy2(t_b[tri_idx][2]),
      .area_recp(t_r[tri_idx]),
      .z0(t_z[tri_idx][0]), .z1(t_z[tri_idx][1]), .z2(t_z[tri_idx][2]),
      .color(t_c[tri_idx]), .rd_row(rd_row), .rd_col(rd_col),
      .rd_color(rd_color), .rd_depth(rd_depth), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   function automatic int run_len(input int n);
      int m = (n > 16) ? 16 : n;
      return (m == 0) ? 9 : 33 + 30 * (m - 1);
   endfunction

   // timing model: counts down the busy window, one done cycle after it
   always @(posedge clk) begin
      if (!rst_n) begin
         rem = 0;
         mdone = 1'b0;
      end else if (mdone) begin
         mdone = 1'b0;
      end else if (rem > 0) begin
         rem = rem - 1;
         if (rem == 0) mdone = 1'b1;
      end else if (start) begin
         rem = run_len(int'(tri_num));
      end
   end

   always @(negedge clk) begin
      if (rst_n && !wd) begin
         chk(busy == (rem > 0), "R1", "busy per cycle", busy, rem > 0);
         chk(done == mdone, "R1", "done per cycle", done, mdone);
      end
   end

   // behavioural rasterizer, compared pixel by pixel (R5 R6 R7 R8 R9 R10)
   task automatic check_tile(input int n, input string req);
      longint zb [8][8];
      longint cb [8][8];
      int m = (n > 16) ? 16 : n;
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) begin
            zb[r][c] = 65535;
            cb[r][c] = 0;
         end
      for (int t = 0; t < m; t++)
         for (int r = 0; r < 8; r++)
            for (int c = 0; c < 8; c++) begin
               longint v [3];
               longint ws = 0, d;
               bit cov = 1'b1;
               for (int k = 0; k < 3; k++) begin
                  v[k] = longint'($signed(t_e[t][k])) + c * longint'($signed(t_a[t][k]))
                       + r * longint'($signed(t_b[t][k]));
                  if (v[k] < 0) cov = 1'b0;
                  ws = ws + v[k] * longint'(t_z[t][k]);
               end
               if (cov) begin
                  d = (ws * longint'(t_r[t])) >>> 16;
                  if (d > 65535) d = 65535;
                  if (d < zb[r][c]) begin
                     zb[r][c] = d;
                     cb[r][c] = longint'(t_c[t]);
                  end
               end
            end
      for (int r = 0; r < 8; r++)
         for (int c = 0; c < 8; c++) begin
            rd_row = 3'(r);
            rd_col = 3'(c);
            #1;
            chk(rd_depth == zb[r][c], req, $sformatf("R10 depth r%0d c%0d", r, c), rd_depth, zb[r][c]);
            chk(rd_color == cb[r][c], req, $sformatf("R10 colour r%0d c%0d", r, c), rd_color, cb[r][c]);
         end
   endtask

   task automatic run_tile(input int n, input string req, input int poke_at, input bit poke_done);
      int cyc = 0;
      @(negedge clk);
      start = 1'b1;
      tri_num = 5'(n);
      @(negedge clk);
      start = 1'b0;
      while (!done && !wd) begin
         if (busy) cyc++;
         start = (cyc == poke_at);
         tri_num = 5'd1;
         @(negedge clk);
      end
      start = 1'b0;
      chk(cyc == run_len(n), req, "busy length", cyc, run_len(n));
      if (poke_done) begin
         start = 1'b1;          // R4: pulse during the done cycle
         @(negedge clk);
         start = 1'b0;
         chk(!busy, "R4", "start in done cycle", busy, 0);
      end
      check_tile(n, req);
   endtask

   task automatic rand_tris();
      for (int t = 0; t < 16; t++) begin
         for (int k = 0; k < 3; k++) begin
            t_e[t][k] = 16'($signed($urandom_range(40)) - 20);
            t_a[t][k] = 16'($signed($urandom_range(12)) - 6);
            t_b[t][k] = 16'($signed($urandom_range(12)) - 6);
            t_z[t][k] = 16'($urandom_range(4095));
         end
         t_r[t] = 16'($urandom_range(8191));
         t_c[t] = 24'($urandom);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      wd = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      for (int t = 0; t < 16; t++) begin
         for (int k = 0; k < 3; k++) begin
            t_e[t][k] = '0; t_a[t][k] = '0; t_b[t][k] = '0; t_z[t][k] = '0;
         end
         t_r[t] = '0;
         t_c[t] = '0;
      end
      repeat (3) @(negedge clk);
      chk(!busy, "R11", "busy after reset", busy, 0);
      chk(!done, "R11", "done after reset", done, 0);
      chk(tri_idx == 0, "R11", "tri_idx after reset", tri_idx, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // directed tile: full cover, equal-depth repeat (R8), nearer partial (R6), order (R9)
      for (int k = 0; k < 3; k++) begin
         t_e[0][k] = 16'd1; t_z[0][k] = 16'd1000;
         t_e[1][k] = 16'd1; t_z[1][k] = 16'd1000;
         t_z[2][k] = 16'd500;
      end
      t_r[0] = 16'd21845; t_c[0] = 24'h111111;
      t_r[1] = 16'd21845; t_c[1] = 24'h222222;
      t_e[2][0] = 16'hFFFD; t_a[2][0] = 16'd1;
      t_e[2][1] = 16'd4;    t_b[2][1] = 16'hFFFF;
      t_e[2][2] = 16'd1;
      t_r[2] = 16'd9000;    t_c[2] = 24'h333333;
      run_tile(3, "R8", -1, 1'b0);

      // saturated depth never beats the cleared value (R7); also re-clears (R5)
      for (int k = 0; k < 3; k++) begin
         t_e[0][k] = 16'd100; t_a[0][k] = '0; t_b[0][k] = '0; t_z[0][k] = 16'hFFFF;
      end
      t_r[0] = 16'hFFFF; t_c[0] = 24'hABCDEF;
      run_tile(1, "R7", -1, 1'b1);

      rand_tris();
      run_tile(16, "R6", -1, 1'b0);
      run_tile(0, "R2", -1, 1'b0);
      rand_tris();
      run_tile(20, "R3", 100, 1'b0);   // R4: start pulsed mid-run
      rand_tris();
      run_tile(5, "R1", 7, 1'b1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule